// File: doc/BRIEF.md
# EDO DRAM Strobe-Sequence Classifier

This block watches the four active-low control strobes of an extended-data-out DRAM interface (row strobe, column strobe, write enable and output enable) on a clock much faster than the memory cycle. It works out what kind of memory cycle the controller just ran. It does this only from the order in which the strobe edges arrive. It never looks at decoded command bits. It sits beside a DRAM sequencer as an independent checker.

Each row-strobe low period, and each column access inside one, ends with a one-cycle valid pulse and a 4-bit class code. Two level flags say who should own the data bus at each moment:

- the memory, which returns read data;
- the controller, which supplies write data.

An error flag marks an edge order that matches no legal cycle. The block resolves events to one sample clock. Nothing finer than that is modelled.

Top module: `dram_seq_classifier`

## Requirements
- R1: After reset, the class output is 0 (standby), the valid pulse and error flag are low, and neither drive flag is set. Whenever both row and column strobes are sampled high and no cycle ends, the class output returns to 0, and both drive flags are low on the next sample.
- R2: A row strobe fall, then a column strobe fall with write enable high, is a read access. When the column strobe rises it is reported with code 1. The memory-drive flag is high while output enable is low during the access.
- R3: Write enable already low when the column strobe falls marks an early write, reported with code 2. The memory-drive flag stays low for the whole access. The controller-drive flag is high while the column strobe stays low. The two drive flags are never high together.
- R4: Write enable falling after the column strobe is low, with output enable never low earlier in that access, is a delayed write, reported with code 3. The controller-drive flag rises after the write enable fall.
- R5: Write enable falling after the column strobe is low, with output enable low before it, is a read-modify-write, reported with code 4. The memory drives the bus until write enable falls. The controller drives it after that.
- R6: The second and later column pulses inside one row strobe low period are page sub-cycles, with these codes: read 5, early write 6, delayed write 7, read-modify-write 8. The row strobe rise that closes a row which had accesses reports nothing further.
- R7: A row strobe low period with no column strobe fall is reported with code 9 when the row strobe rises.
- R8: The column strobe falls while the row strobe is high and write enable is high, then the row strobe falls. This is a column-before-row refresh. If the row strobe stayed low for fewer than SELF_CYCLES samples, it is reported with code 10 when the row strobe rises.
- R9: The same column-first entry with the row strobe low for at least SELF_CYCLES samples is a self-refresh, reported with code 12.
- R10: A read access can end with the row strobe rising while the column strobe stays low; it is then reported with code 1 at that rise. If the row strobe falls again with the column strobe still held, that refresh is a hidden refresh, reported with code 11. The memory-drive flag stays high through the hidden refresh while output enable is low.
- R11: The memory-drive flag stays high after the column strobe rises while the row strobe is still low. It drops when output enable goes high and returns when output enable goes low again. It drops once the later of the two strobes has risen.
- R12: Any of these orders is illegal and is reported at the row strobe rise with code 15 and the error flag set:
  - row and column strobes falling on the same sample;
  - a column-first refresh entered with write enable low;
  - a column strobe fall inside a refresh.
- R13: Every reported cycle gives exactly one valid pulse one sample long. The class output holds the code while valid is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ras_n_i | input | 1 | Row address strobe, active low |
| cas_n_i | input | 1 | Column address strobe, active low |
| we_n_i | input | 1 | Write enable, active low |
| oe_n_i | input | 1 | Output enable, active low |
| cyc_valid_o | output | 1 | One-sample pulse when a cycle is classified |
| cyc_class_o | output | 4 | Class code of the cycle (codes in R1 to R12) |
| seq_err_o | output | 1 | Set with the valid pulse for an illegal order |
| mem_drv_o | output | 1 | Memory should be driving the data bus |
| ctl_drv_o | output | 1 | Controller should be driving the data bus |

## Verification
The bench covers every class with its own strobe sequence. Three sets of tests each pin down one deciding detail:

- The three write types differ only in where write enable falls and whether output enable came first, so they show that the block uses the position of the write enable edge.
- A hidden refresh is compared with a column-first refresh that starts from a released column strobe. A short column-first refresh is compared with one held past the self-refresh length. These show that a refresh is classed by its entry order and by its length.
- One page burst mixes read, early write and delayed write sub-cycles. The illegal orders are also run.

These tests together cover the page code offset, the suppressed report at the end of a row, and the error path.

// File: rtl/dram_cls_pkg.sv
package dram_cls_pkg;

   typedef enum logic [3:0] {
      CLS_IDLE   = 4'd0,
      CLS_RD     = 4'd1,
      CLS_EWR    = 4'd2,
      CLS_DWR    = 4'd3,
      CLS_RMW    = 4'd4,
      CLS_PG_RD  = 4'd5,
      CLS_PG_EWR = 4'd6,
      CLS_PG_DWR = 4'd7,
      CLS_PG_RMW = 4'd8,
      CLS_ROR    = 4'd9,
      CLS_CBR    = 4'd10,
      CLS_HID    = 4'd11,
      CLS_SELF   = 4'd12,
      CLS_BAD    = 4'd15
   } cls_e;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_ROW  = 2'd1,
      ST_REF  = 2'd2
   } trk_st_e;

   // active-low strobe levels as sampled
   typedef struct packed {
      logic ras_n;
      logic cas_n;
      logic we_n;
      logic oe_n;
   } strb_t;

   typedef struct packed {
      logic ras_fall;
      logic ras_rise;
      logic cas_fall;
      logic cas_rise;
      logic we_fall;
   } evt_t;

   function automatic cls_e page_of(input cls_e k);
      case (k)
         CLS_RD:  page_of = CLS_PG_RD;
         CLS_EWR: page_of = CLS_PG_EWR;
         CLS_DWR: page_of = CLS_PG_DWR;
         CLS_RMW: page_of = CLS_PG_RMW;
         default: page_of = CLS_BAD;
      endcase
   endfunction

endpackage

// File: rtl/strobe_sampler.sv
module strobe_sampler
   import dram_cls_pkg::*;
#(
   parameter int STAGES = 1
)(
   input  logic  clk,
   input  logic  rst_n,
   input  strb_t pin,
   output strb_t cur,
   output evt_t  evt
);
   localparam int PW = 4 * STAGES;

   logic [PW-1:0] pipe;
   strb_t         prv;

   generate
      if (STAGES == 1) begin : g_one
         always_ff @(posedge clk) begin
            if (!rst_n) pipe <= '1;
            else        pipe <= pin;
         end
      end else begin : g_many
         always_ff @(posedge clk) begin
            if (!rst_n) pipe <= '1;
            else        pipe <= {pipe[PW-5:0], pin};
         end
      end
   endgenerate

   assign cur = strb_t'(pipe[PW-1 -: 4]);

   always_ff @(posedge clk) begin
      if (!rst_n) prv <= '1;
      else        prv <= cur;
   end

   always_comb begin
      evt.ras_fall = prv.ras_n & ~cur.ras_n;
      evt.ras_rise = ~prv.ras_n & cur.ras_n;
      evt.cas_fall = prv.cas_n & ~cur.cas_n;
      evt.cas_rise = ~prv.cas_n & cur.cas_n;
      evt.we_fall  = prv.we_n & ~cur.we_n;
   end

endmodule

// File: rtl/cycle_tracker.sv
module cycle_tracker
   import dram_cls_pkg::*;
#(
   parameter int SELF_CYCLES = 5000
)(
   input  logic       clk,
   input  logic       rst_n,
   input  strb_t      cur,
   input  evt_t       evt,
   output logic       valid_o,
   output logic [3:0] cls_o,
   output logic       err_o
);
   localparam int             CNT_W  = $clog2(SELF_CYCLES + 1);
   localparam logic [CNT_W-1:0] SELF_L = CNT_W'(SELF_CYCLES);

   trk_st_e          st_q, st_d;
   logic             acc_q, acc_d;     // column access open
   logic             had_q, had_d;     // row already had an access
   cls_e             kind_q, kind_d;
   logic             oes_q, oes_d;     // OE seen low in this access
   logic             held_q, held_d;   // CAS kept low from an access
   logic             hid_q, hid_d;
   logic             bad_q, bad_d;
   logic [CNT_W-1:0] cnt_q, cnt_d;
   logic             emit;
   cls_e             code;

   always_comb begin
      st_d = st_q;  acc_d = acc_q;  had_d = had_q;  kind_d = kind_q;
      oes_d = oes_q; held_d = held_q; hid_d = hid_q; bad_d = bad_q;
      cnt_d = cnt_q; emit = 1'b0;  code = CLS_IDLE;
      case (st_q)
         ST_IDLE: begin
            if (evt.cas_rise) held_d = 1'b0;
            if (evt.ras_fall) begin
               if (!cur.cas_n) begin
                  st_d  = ST_REF;
                  hid_d = held_q && !evt.cas_fall;
                  bad_d = evt.cas_fall || (!held_q && !cur.we_n);
                  cnt_d = CNT_W'(1);
               end else begin
                  st_d  = ST_ROW;
                  acc_d = 1'b0;
                  had_d = 1'b0;
               end
            end
         end
         ST_ROW: begin
            if (acc_q && !cur.cas_n && !cur.oe_n) oes_d = 1'b1;
            if (acc_q && !cur.cas_n && evt.we_fall && kind_q == CLS_RD)
               kind_d = oes_q ? CLS_RMW : CLS_DWR;
            if (evt.cas_fall && !evt.ras_rise) begin
               acc_d  = 1'b1;
               kind_d = cur.we_n ? CLS_RD : CLS_EWR;
               oes_d  = !cur.oe_n;
            end
            if (evt.ras_rise) begin
               st_d = ST_IDLE;
               if (acc_q) begin
                  emit   = 1'b1;
                  code   = had_q ? page_of(kind_d) : kind_d;
                  held_d = !cur.cas_n;
               end else if (!had_q) begin
                  emit = 1'b1;
                  code = CLS_ROR;
               end
               acc_d = 1'b0;
            end else if (evt.cas_rise && acc_q) begin
               emit  = 1'b1;
               code  = had_q ? page_of(kind_d) : kind_d;
               acc_d = 1'b0;
               had_d = 1'b1;
            end
         end
         ST_REF: begin
            if (cnt_q < SELF_L) cnt_d = cnt_q + CNT_W'(1);
            if (evt.cas_fall) bad_d = 1'b1;
            if (evt.ras_rise) begin
               st_d   = ST_IDLE;
               emit   = 1'b1;
               held_d = hid_q && !cur.cas_n;
               if (bad_d)               code = CLS_BAD;
               else if (hid_q)          code = CLS_HID;
               else if (cnt_q >= SELF_L) code = CLS_SELF;
               else                     code = CLS_CBR;
            end
         end
         default: st_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q <= ST_IDLE;  acc_q <= 1'b0; had_q <= 1'b0; kind_q <= CLS_RD;
         oes_q <= 1'b0;    held_q <= 1'b0; hid_q <= 1'b0; bad_q <= 1'b0;
         cnt_q <= '0;
         valid_o <= 1'b0;  cls_o <= CLS_IDLE; err_o <= 1'b0;
      end else begin
         st_q <= st_d;  acc_q <= acc_d; had_q <= had_d; kind_q <= kind_d;
         oes_q <= oes_d; held_q <= held_d; hid_q <= hid_d; bad_q <= bad_d;
         cnt_q <= cnt_d;
         valid_o <= emit;
         err_o   <= emit && (code == CLS_BAD);
         if (emit)                       cls_o <= code;
         else if (cur.ras_n && cur.cas_n) cls_o <= CLS_IDLE;
      end
   end

   a_r13_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      valid_o |=> !valid_o);

   a_r12_err_has_valid: assert property (@(posedge clk) disable iff (!rst_n)
      err_o |-> valid_o);

   // R7 R8 R9 R10: refresh-class reports come only from a row strobe rise
   a_r8_refresh_on_ras_rise: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_o && (cls_o == CLS_ROR || cls_o == CLS_CBR ||
                   cls_o == CLS_HID || cls_o == CLS_SELF)) |-> $past(cur.ras_n));

endmodule

// File: rtl/dq_owner.sv
module dq_owner
   import dram_cls_pkg::*;
(
   input  logic  clk,
   input  logic  rst_n,
   input  strb_t cur,
   input  logic  cas_fall,
   input  logic  cas_rise,
   input  logic  we_fall,
   output logic  mem_drv_o,
   output logic  ctl_drv_o
);
   logic rd_q, rd_d;   // read data latched by the memory
   logic wr_q, wr_d;   // write data phase

   always_comb begin
      rd_d = rd_q;
      wr_d = wr_q;
      if (cas_fall && !cur.ras_n) begin
         rd_d = cur.we_n;
         wr_d = !cur.we_n;
      end else if (we_fall && !cur.cas_n && rd_q) begin
         rd_d = 1'b0;
         wr_d = 1'b1;
      end
      if (cas_rise) wr_d = 1'b0;
      if (cur.ras_n && cur.cas_n) begin
         rd_d = 1'b0;
         wr_d = 1'b0;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rd_q <= 1'b0; wr_q <= 1'b0;
         mem_drv_o <= 1'b0; ctl_drv_o <= 1'b0;
      end else begin
         rd_q <= rd_d; wr_q <= wr_d;
         mem_drv_o <= rd_d & ~cur.oe_n;
         ctl_drv_o <= wr_d;
      end
   end

   a_r3_no_bus_fight: assert property (@(posedge clk) disable iff (!rst_n)
      !(mem_drv_o && ctl_drv_o));

   a_r1_standby_hiz: assert property (@(posedge clk) disable iff (!rst_n)
      (cur.ras_n && cur.cas_n) |=> (!mem_drv_o && !ctl_drv_o));

   a_r3_early_write_hiz: assert property (@(posedge clk) disable iff (!rst_n)
      (cas_fall && !cur.ras_n && !cur.we_n) |=> !mem_drv_o);

   a_r11_oe_release: assert property (@(posedge clk) disable iff (!rst_n)
      cur.oe_n |=> !mem_drv_o);

endmodule

// File: rtl/dram_seq_classifier.sv
module dram_seq_classifier
   import dram_cls_pkg::*;
#(
   parameter int SELF_CYCLES = 5000,  // 100 us at 50 MHz
   parameter int SYNC_STAGES = 1
)(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       ras_n_i,
   input  logic       cas_n_i,
   input  logic       we_n_i,
   input  logic       oe_n_i,
   output logic       cyc_valid_o,
   output logic [3:0] cyc_class_o,
   output logic       seq_err_o,
   output logic       mem_drv_o,
   output logic       ctl_drv_o
);
   generate
      if (SELF_CYCLES < 2) begin : g_chk_self
         $error("SELF_CYCLES must be at least 2");
      end
      if (SYNC_STAGES < 1 || SYNC_STAGES > 3) begin : g_chk_sync
         $error("SYNC_STAGES must be 1, 2 or 3");
      end
   endgenerate

   strb_t pin, cur;
   evt_t  evt;

   assign pin = '{ras_n: ras_n_i, cas_n: cas_n_i, we_n: we_n_i, oe_n: oe_n_i};

   strobe_sampler #(.STAGES(SYNC_STAGES)) u_smp (
      .clk(clk), .rst_n(rst_n), .pin(pin), .cur(cur), .evt(evt));

   cycle_tracker #(.SELF_CYCLES(SELF_CYCLES)) u_trk (
      .clk(clk), .rst_n(rst_n), .cur(cur), .evt(evt),
      .valid_o(cyc_valid_o), .cls_o(cyc_class_o), .err_o(seq_err_o));

   dq_owner u_dq (
      .clk(clk), .rst_n(rst_n), .cur(cur),
      .cas_fall(evt.cas_fall), .cas_rise(evt.cas_rise), .we_fall(evt.we_fall),
      .mem_drv_o(mem_drv_o), .ctl_drv_o(ctl_drv_o));

endmodule

// File: tb/sim_dram_seq_classifier.sv
module sim_dram_seq_classifier;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
   logic       valid, err, mem_drv, ctl_drv;
   logic [3:0] cls;

   int nchk = 0, nerr = 0, nv = 0;
   logic [3:0] last_cls = 4'd0;
   logic       last_err = 1'b0;

   always #10 clk = ~clk;

   dram_seq_classifier u0 (
      .clk(clk), .rst_n(rst_n), .ras_n_i(ras_n), .cas_n_i(cas_n),
      .we_n_i(we_n), .oe_n_i(oe_n), .cyc_valid_o(valid), .cyc_class_o(cls),
      .seq_err_o(err), .mem_drv_o(mem_drv), .ctl_drv_o(ctl_drv));

   always @(negedge clk) begin
      if (valid) begin
         nv++;
         last_cls = cls;
         last_err = err;
      end
   end

   task automatic wt(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic chk(input string tag, input int act, input int exp);
      nchk++;
      if (act !== exp) begin
         nerr++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic all_high();
      ras_n = 1; cas_n = 1; we_n = 1; oe_n = 1;
      wt(4);
   endtask

   task automatic t_reset();
      chk("R1 reset class", cls, 0);
      chk("R1 reset valid", valid, 0);
      chk("R1 reset mem_drv", mem_drv, 0);
      chk("R1 reset ctl_drv", ctl_drv, 0);
   endtask

   task automatic t_read();
      int v0 = nv;
      ras_n = 0; wt(3);
      oe_n = 0; cas_n = 0; wt(3);
      chk("R2 read mem_drv", mem_drv, 1);
      oe_n = 1; wt(3);
      chk("R11 oe high releases", mem_drv, 0);
      oe_n = 0; wt(3);
      chk("R11 oe low restores", mem_drv, 1);
      cas_n = 1; wt(3);
      chk("R2 read code", last_cls, 1);
      chk("R13 one pulse", nv - v0, 1);
      chk("R11 extended data after cas rise", mem_drv, 1);
      ras_n = 1; wt(3);
      chk("R11 released after later rise", mem_drv, 0);
      chk("R1 standby class", cls, 0);
      oe_n = 1; wt(2);
   endtask

   task automatic t_early_write();
      ras_n = 0; wt(3);
      we_n = 0; wt(1);
      cas_n = 0; wt(3);
      chk("R3 early write mem_drv", mem_drv, 0);
      chk("R3 early write ctl_drv", ctl_drv, 1);
      cas_n = 1; wt(3);
      chk("R3 early write code", last_cls, 2);
      chk("R3 ctl_drv off", ctl_drv, 0);
      we_n = 1; ras_n = 1; wt(3);
   endtask

   task automatic t_delayed_write();
      ras_n = 0; wt(3);
      cas_n = 0; wt(3);
      chk("R4 before we fall ctl_drv", ctl_drv, 0);
      we_n = 0; wt(3);
      chk("R4 delayed ctl_drv", ctl_drv, 1);
      cas_n = 1; wt(3);
      chk("R4 delayed write code", last_cls, 3);
      we_n = 1; ras_n = 1; wt(3);
   endtask

   task automatic t_rmw();
      ras_n = 0; wt(3);
      oe_n = 0; cas_n = 0; wt(3);
      chk("R5 rmw read phase mem_drv", mem_drv, 1);
      oe_n = 1; wt(1);
      we_n = 0; wt(3);
      chk("R5 rmw write phase ctl_drv", ctl_drv, 1);
      chk("R5 rmw write phase mem_drv", mem_drv, 0);
      cas_n = 1; wt(3);
      chk("R5 rmw code", last_cls, 4);
      we_n = 1; ras_n = 1; wt(3);
   endtask

   task automatic t_page();
      int v0;
      ras_n = 0; wt(3);
      cas_n = 0; wt(3); cas_n = 1; wt(3);
      chk("R6 first page access is plain read", last_cls, 1);
      we_n = 0; cas_n = 0; wt(3); cas_n = 1; we_n = 1; wt(3);
      chk("R6 page early write", last_cls, 6);
      cas_n = 0; wt(2); we_n = 0; wt(3); cas_n = 1; wt(3);
      chk("R6 page delayed write", last_cls, 7);
      we_n = 1;
      v0 = nv;
      ras_n = 1; wt(4);
      chk("R6 row close silent", nv - v0, 0);
   endtask

   task automatic t_ras_only();
      int v0 = nv;
      ras_n = 0; wt(5);
      ras_n = 1; wt(3);
      chk("R7 ras-only code", last_cls, 9);
      chk("R13 ras-only single pulse", nv - v0, 1);
   endtask

   task automatic t_cbr(input int hold, input int exp, input string tag);
      cas_n = 0; wt(3);
      ras_n = 0; wt(hold);
      ras_n = 1; wt(3);
      chk(tag, last_cls, exp);
      chk({tag, " no error"}, last_err, 0);
      cas_n = 1; wt(3);
   endtask

   task automatic t_hidden();
      ras_n = 0; wt(3);
      oe_n = 0; cas_n = 0; wt(3);
      ras_n = 1; wt(3);
      chk("R10 read before hidden", last_cls, 1);
      chk("R10 data held after ras rise", mem_drv, 1);
      ras_n = 0; wt(10);
      chk("R10 data held in refresh", mem_drv, 1);
      ras_n = 1; wt(3);
      chk("R10 hidden refresh code", last_cls, 11);
      cas_n = 1; wt(3);
      chk("R11 released after cas rise", mem_drv, 0);
      oe_n = 1; wt(2);
   endtask

   task automatic t_illegal();
      ras_n = 0; cas_n = 0; wt(5);
      ras_n = 1; wt(3);
      chk("R12 simultaneous fall code", last_cls, 15);
      chk("R12 simultaneous fall err", last_err, 1);
      cas_n = 1; wt(3);
      we_n = 0; cas_n = 0; wt(3);
      ras_n = 0; wt(5);
      ras_n = 1; wt(3);
      chk("R12 refresh with we low", last_cls, 15);
      cas_n = 1; we_n = 1; wt(3);
      cas_n = 0; wt(3); ras_n = 0; wt(3);
      cas_n = 1; wt(2); cas_n = 0; wt(3);
      ras_n = 1; wt(3);
      chk("R12 cas refall in refresh", last_cls, 15);
      chk("R12 err flag", last_err, 1);
      cas_n = 1; wt(3);
   endtask

   initial begin
      wt(4);
      rst_n = 1;
      wt(2);
      t_reset();
      t_read();
      all_high();
      t_early_write();
      all_high();
      t_delayed_write();
      all_high();
      t_rmw();
      all_high();
      t_page();
      all_high();
      t_ras_only();
      all_high();
      t_cbr(20, 10, "R8 short cbr refresh");
      all_high();
      t_cbr(5050, 12, "R9 self refresh");
      all_high();
      t_hidden();
      all_high();
      t_illegal();
      all_high();
      chk("R1 final standby class", cls, 0);
      $display("  Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      nerr++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
   end

endmodule